// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core serves next. It watches five hardware request lines and one software restart request. The hardware lines are a non-maskable line, an edge-latched line, two level lines with their own mask bits, and an external line that is answered with an acknowledge strobe. The block picks one winner by fixed priority and gives the core a 16-bit vector address.

The core signals the end of each instruction with `instr_end`. Requests are sampled only on that strobe, so the current instruction always finishes first. A granted request is held on `req_valid`, `req_vector` and `req_source` until the core pulses `ack`. The block owns the global interrupt enable and the three-bit mask. The core changes them through set, clear and write strobes, and both can be read back on the outputs.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first request is granted, `req_valid`=0, `req_vector`=0000h, `req_source`=0, `ext_ack_n`=1, `gie`=0 and `mask`=3'b111.
- R2: Priority from highest to lowest is non-maskable, edge line, high level line, low level line, external line, software restart. `req_source` encodes these as 1, 2, 3, 4, 5 and 6, and 0 means no request.
- R3: The fixed vectors are 0024h (non-maskable), 003Ch (edge line), 0034h (high level line), 002Ch (low level line) and `EXT_VECTOR` (default 0038h) for the external line.
- R4: The non-maskable line ignores `gie` and `mask`. It is pending only after a rising edge, and only while the pin has stayed high since that edge. Once it is acknowledged, the pin must fall and rise again before it can be granted again.
- R5: A rising edge on `irq_edge` is latched even if the pin falls before the next boundary. The latch clears when a granted edge-line request is acknowledged or when `edge_clr` is high. A new edge in the same cycle wins over the clear.
- R6: The two level lines and the external line are pending only while their pin is high. All maskable lines also need `gie`=1. A mask bit of 1 blocks its line: bit 2 blocks the edge line, bit 1 the high level line and bit 0 the low level line. A masked edge stays latched.
- R7: A request is granted at a clock edge only when `instr_end`=1 and no request is outstanding. `req_valid` rises in the next cycle and holds a stable vector until `ack`. The cycle after `ack`, `req_valid`=0 and the vector is 0000h.
- R8: Granting any maskable or external request clears `gie`. Granting a non-maskable or software request leaves `gie` unchanged. A grant wins over `gie_set`.
- R9: Granting the external line drives `ext_ack_n` low for exactly one cycle, the first cycle in which `req_valid` is high. At all other times `ext_ack_n` is high.
- R10: A software restart with number n, for n = 0 to 7, vectors to n*8 (0000h to 0038h). It does not need `gie`.
- R11: `gie_set` sets `gie` and `gie_clr` clears it, with clear winning over set. `mask_wr` loads `mask_in` into `mask` at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_nmi | input | 1 | Non-maskable request pin |
| irq_edge | input | 1 | Edge-latched maskable request pin |
| irq_lvl_hi | input | 1 | Higher-priority level request pin |
| irq_lvl_lo | input | 1 | Lower-priority level request pin |
| irq_ext | input | 1 | External level request pin, acknowledged by strobe |
| sw_req | input | 1 | Software restart request |
| sw_num | input | 3 | Software restart number |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| mask_wr | input | 1 | Load the mask register |
| mask_in | input | 3 | New mask value (bit 2 edge, bit 1 high level, bit 0 low level) |
| edge_clr | input | 1 | Clear the edge latch |
| instr_end | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Core has taken the granted vector |
| req_valid | output | 1 | A request is granted and outstanding |
| req_vector | output | 16 | Vector address of the granted request |
| req_source | output | 3 | Code of the granted source |
| ext_ack_n | output | 1 | Active-low acknowledge for the external line |
| gie | output | 1 | Global interrupt enable |
| mask | output | 3 | Current mask |

## Verification
Most internal state can only be seen at the ports at the next instruction boundary, when it affects which request is granted. A stale edge latch or an armed non-maskable flag that fails to clear shows up as an extra grant. A lost latch shows up as a missing grant, one cycle after the first `instr_end` that should have found it. Faults in the enable and the mask are visible on `gie` and `mask` one cycle after the strobe that should have changed them. A wrong priority or vector shows up on `req_source` and `req_vector` in the first cycle of the grant. The bench therefore pulses boundaries right after each stimulus, and it compares every output against a behavioural model on every clock.

// File: rtl/vic_pkg.sv
// Shared source codes and vector constants for the vectored interrupt controller.
// Assumes a 16-bit vector space and a restart stride of eight bytes.
package vic_pkg;

    localparam int VEC_W     = 16;
    localparam int NUM_HW    = 5;
    localparam int STRIDE_SH = 3;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_NMI    = 3'd1,
        SRC_EDGE   = 3'd2,
        SRC_LVL_HI = 3'd3,
        SRC_LVL_LO = 3'd4,
        SRC_EXT    = 3'd5,
        SRC_SW     = 3'd6
    } src_e;

    localparam logic [VEC_W-1:0] VEC_NMI    = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_EDGE   = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_LVL_HI = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LVL_LO = 16'h002C;

endpackage

// File: rtl/vic_pin_capture.sv
// Per-pin request capture. LATCH_EDGE=1 remembers any rising edge until it is
// cleared (a new edge wins over the clear). LATCH_EDGE=0 arms on a rising edge
// and reports a request only while the pin stays high. The armed flag drops
// when the pin falls or when the request is cleared.
// Assumes the pin is already synchronous to clk.
module vic_pin_capture #(
    parameter bit LATCH_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic clr,
    output logic pend
);

    logic pin_d;
    logic flag;
    logic rise;

    assign rise = pin && !pin_d;

    // Delayed copy of the pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= 1'b0;
        else        pin_d <= pin;
    end

    generate
        if (LATCH_EDGE) begin : g_latch
            // Edge latch: set on rise, cleared by clr unless a new rise arrives.
            always_ff @(posedge clk) begin
                if (!rst_n)   flag <= 1'b0;
                else if (rise) flag <= 1'b1;
                else if (clr)  flag <= 1'b0;
            end
            assign pend = flag;

            AST_EDGE_REMEMBERED: assert property (@(posedge clk) disable iff (!rst_n)
                rise |=> flag); // R5
            AST_EDGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !rise) |=> !flag); // R5
        end else begin : g_armed
            // Armed flag: set on rise, dropped when the pin falls or on clear.
            always_ff @(posedge clk) begin
                if (!rst_n)           flag <= 1'b0;
                else if (!pin || clr) flag <= 1'b0;
                else if (!pin_d)      flag <= 1'b1;
            end
            assign pend = flag && pin;

            AST_NMI_DISARM_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                !pin |=> !flag); // R4
        end
    endgenerate

endmodule

// File: rtl/vic_enable_regs.sv
// Global enable and per-line mask registers. A maskable grant clears the
// enable and wins over the set and clear strobes. Clear wins over set.
// Reset leaves every line masked and the enable off.
module vic_enable_regs #(
    parameter int MASK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              take_maskable,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_in,
    output logic              gie,
    output logic [MASK_W-1:0] mask
);

    localparam logic [MASK_W-1:0] MASK_ALL = {MASK_W{1'b1}};

    // Global enable: grant and clear beat set.
    always_ff @(posedge clk) begin
        if (!rst_n)                       gie <= 1'b0;
        else if (take_maskable || en_clr) gie <= 1'b0;
        else if (en_set)                  gie <= 1'b1;
    end

    // Mask register: load on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= MASK_ALL;
        else if (mask_wr) mask <= mask_in;
    end

    AST_GRANT_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_maskable |=> !gie); // R8
    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(mask_in))); // R11

endmodule

// File: rtl/vic_resolver.sv
// Combinational priority resolver. Hardware index 0 has the highest priority.
// Software restart ranks below every hardware line. Produces the winning
// source and its vector.
module vic_resolver
    import vic_pkg::*;
#(
    parameter int               NUM_W      = 3,
    parameter logic [VEC_W-1:0] EXT_VECTOR = 16'h0038
) (
    input  logic [NUM_HW-1:0] pend_hw,
    input  logic              sw_req,
    input  logic [NUM_W-1:0]  sw_num,
    output src_e              win,
    output logic [VEC_W-1:0]  win_vec
);

    // Pick the highest-priority pending source.
    always_comb begin
        win = sw_req ? SRC_SW : SRC_NONE;
        for (int i = NUM_HW - 1; i >= 0; i--) begin
            if (pend_hw[i]) win = src_e'(3'(i + 1));
        end
    end

    // Map the winner to its vector address.
    always_comb begin
        case (win)
            SRC_NMI:    win_vec = VEC_NMI;
            SRC_EDGE:   win_vec = VEC_EDGE;
            SRC_LVL_HI: win_vec = VEC_LVL_HI;
            SRC_LVL_LO: win_vec = VEC_LVL_LO;
            SRC_EXT:    win_vec = EXT_VECTOR;
            SRC_SW:     win_vec = VEC_W'(sw_num) << STRIDE_SH;
            default:    win_vec = '0;
        endcase
    end

endmodule

// File: rtl/vectored_irq_ctrl.sv
// Top of the vectored interrupt controller. Captures the request pins, gates
// them with the enable and the mask, and resolves one winner per instruction
// boundary. It holds the grant until the core acknowledges it.
// Assumes all inputs are synchronous to clk and that ack only comes while a
// grant is outstanding (otherwise it is ignored).
module vectored_irq_ctrl
    import vic_pkg::*;
#(
    parameter int                 NUM_W      = 3,
    parameter int                 MASK_W     = 3,
    parameter logic [VEC_W-1:0]   EXT_VECTOR = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_nmi,
    input  logic              irq_edge,
    input  logic              irq_lvl_hi,
    input  logic              irq_lvl_lo,
    input  logic              irq_ext,
    input  logic              sw_req,
    input  logic [NUM_W-1:0]  sw_num,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_in,
    input  logic              edge_clr,
    input  logic              instr_end,
    input  logic              ack,
    output logic              req_valid,
    output logic [VEC_W-1:0]  req_vector,
    output logic [2:0]        req_source,
    output logic              ext_ack_n,
    output logic              gie,
    output logic [MASK_W-1:0] mask
);

    localparam int MB_EDGE = 2;
    localparam int MB_HI   = 1;
    localparam int MB_LO   = 0;

    logic             pend_nmi, edge_held;
    logic [NUM_HW-1:0] pend_hw;
    src_e             win, src_q;
    logic [VEC_W-1:0] win_vec, vec_q;
    logic             valid_q, ack_n_q;
    logic             accept, ack_hit, take_maskable;

    assign ack_hit       = valid_q && ack;
    assign accept        = instr_end && !valid_q;
    assign take_maskable = accept && (win inside {SRC_EDGE, SRC_LVL_HI, SRC_LVL_LO, SRC_EXT});

    vic_pin_capture #(.LATCH_EDGE(1'b0)) u_nmi_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (irq_nmi),
        .clr  (ack_hit && (src_q == SRC_NMI)),
        .pend (pend_nmi)
    );

    vic_pin_capture #(.LATCH_EDGE(1'b1)) u_edge_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (irq_edge),
        .clr  ((ack_hit && (src_q == SRC_EDGE)) || edge_clr),
        .pend (edge_held)
    );

    vic_enable_regs #(.MASK_W(MASK_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_set       (gie_set),
        .en_clr       (gie_clr),
        .take_maskable(take_maskable),
        .mask_wr      (mask_wr),
        .mask_in      (mask_in),
        .gie          (gie),
        .mask         (mask)
    );

    // Gate each hardware line with enable and mask, in priority order.
    always_comb begin
        pend_hw[0] = pend_nmi;
        pend_hw[1] = edge_held  && !mask[MB_EDGE] && gie;
        pend_hw[2] = irq_lvl_hi && !mask[MB_HI]   && gie;
        pend_hw[3] = irq_lvl_lo && !mask[MB_LO]   && gie;
        pend_hw[4] = irq_ext    && gie;
    end

    vic_resolver #(.NUM_W(NUM_W), .EXT_VECTOR(EXT_VECTOR)) u_res (
        .pend_hw(pend_hw),
        .sw_req (sw_req),
        .sw_num (sw_num),
        .win    (win),
        .win_vec(win_vec)
    );

    // Grant register: load at a free boundary, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            src_q   <= SRC_NONE;
            vec_q   <= '0;
            ack_n_q <= 1'b1;
        end else begin
            ack_n_q <= 1'b1;
            if (ack_hit) begin
                valid_q <= 1'b0;
                src_q   <= SRC_NONE;
                vec_q   <= '0;
            end else if (accept && (win != SRC_NONE)) begin
                valid_q <= 1'b1;
                src_q   <= win;
                vec_q   <= win_vec;
                ack_n_q <= (win != SRC_EXT);
            end
        end
    end

    assign req_valid  = valid_q;
    assign req_vector = vec_q;
    assign req_source = src_q;
    assign ext_ack_n  = ack_n_q;

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack) |=> (req_valid && $stable(req_vector))); // R7
    AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(instr_end)); // R7
    AST_EXT_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack_n |-> (req_valid && (req_source == 3'd5))); // R9
    AST_EXT_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack_n |=> ext_ack_n); // R9

endmodule

// File: tb/test_vectored_irq_ctrl.sv
`timescale 1ns/1ps
module test_vectored_irq_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_nmi = 0, irq_edge = 0, irq_lvl_hi = 0, irq_lvl_lo = 0, irq_ext = 0;
    logic sw_req = 0;
    logic [2:0] sw_num = 0;
    logic gie_set = 0, gie_clr = 0, mask_wr = 0, edge_clr = 0, instr_end = 0, ack = 0;
    logic [2:0] mask_in = 0;
    logic req_valid, ext_ack_n, gie;
    logic [15:0] req_vector;
    logic [2:0] req_source, mask;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vectored_irq_ctrl i_vectored_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_nmi(irq_nmi), .irq_edge(irq_edge),
        .irq_lvl_hi(irq_lvl_hi), .irq_lvl_lo(irq_lvl_lo), .irq_ext(irq_ext),
        .sw_req(sw_req), .sw_num(sw_num), .gie_set(gie_set), .gie_clr(gie_clr),
        .mask_wr(mask_wr), .mask_in(mask_in), .edge_clr(edge_clr),
        .instr_end(instr_end), .ack(ack), .req_valid(req_valid),
        .req_vector(req_vector), .req_source(req_source), .ext_ack_n(ext_ack_n),
        .gie(gie), .mask(mask)
    );

    // Behavioural reference model state.
    int m_req, m_vec, m_src, m_inta, m_gie, m_mask, m_tarm, m_tprev, m_lat, m_eprev;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model update, using the inputs that are stable at the edge.
    always @(posedge clk) begin
        int win, wvec, nt, nl, acc, hit;
        if (!rst_n) begin
            m_req = 0; m_vec = 0; m_src = 0; m_inta = 1; m_gie = 0; m_mask = 7;
            m_tarm = 0; m_tprev = 0; m_lat = 0; m_eprev = 0;
        end else begin
            if (m_tarm && irq_nmi) win = 1;
            else if (m_lat && !((m_mask >> 2) & 1) && m_gie) win = 2;
            else if (irq_lvl_hi && !((m_mask >> 1) & 1) && m_gie) win = 3;
            else if (irq_lvl_lo && !(m_mask & 1) && m_gie) win = 4;
            else if (irq_ext && m_gie) win = 5;
            else if (sw_req) win = 6;
            else win = 0;
            case (win)
                1: wvec = 'h24; 2: wvec = 'h3C; 3: wvec = 'h34; 4: wvec = 'h2C;
                5: wvec = 'h38; 6: wvec = sw_num * 8; default: wvec = 0;
            endcase
            acc = instr_end && !m_req;
            hit = m_req && ack;
            nt = m_tarm;
            if (irq_nmi && !m_tprev) nt = 1;
            if (!irq_nmi) nt = 0;
            if (hit && m_src == 1) nt = 0;
            nl = m_lat;
            if ((hit && m_src == 2) || edge_clr) nl = 0;
            if (irq_edge && !m_eprev) nl = 1;
            if (acc && win >= 2 && win <= 5) m_gie = 0;
            else if (gie_clr) m_gie = 0;
            else if (gie_set) m_gie = 1;
            if (mask_wr) m_mask = mask_in;
            m_inta = 1;
            if (hit) begin
                m_req = 0; m_src = 0; m_vec = 0;
            end else if (acc && win != 0) begin
                m_req = 1; m_src = win; m_vec = wvec; m_inta = (win != 5);
            end
            m_tarm = nt; m_tprev = irq_nmi; m_lat = nl; m_eprev = irq_edge;
        end
    end

    // Compare every output with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_valid == m_req[0], "R7", "model req_valid", req_valid, m_req);
            chk(req_vector == m_vec[15:0], "R3", "model req_vector", req_vector, m_vec);
            chk(req_source == m_src[2:0], "R2", "model req_source", req_source, m_src);
            chk(ext_ack_n == m_inta[0], "R9", "model ext_ack_n", ext_ack_n, m_inta);
            chk(gie == m_gie[0], "R8", "model gie", gie, m_gie);
            chk(mask == m_mask[2:0], "R11", "model mask", mask, m_mask);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic boundary();
        instr_end = 1; tick(); instr_end = 0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic expect_grant(input string req, input int src, input int vec);
        chk(req_valid == 1'b1, req, "grant valid", req_valid, 1);
        chk(req_source == src[2:0], req, "grant source", req_source, src);
        chk(req_vector == vec[15:0], req, "grant vector", req_vector, vec);
    endtask

    task automatic expect_none(input string req);
        chk(req_valid == 1'b0, req, "no grant", req_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_valid == 0 && req_vector == 0 && req_source == 0, "R1", "reset grant", req_vector, 0);
        chk(ext_ack_n == 1, "R1", "reset ext_ack_n", ext_ack_n, 1);
        chk(gie == 0 && mask == 3'b111, "R1", "reset gie/mask", {gie, mask}, 4'b0111);
        rst_n = 1;
        tick();
        chk(gie == 0 && mask == 3'b111 && req_valid == 0, "R1", "post-reset", {gie, mask}, 4'b0111);

        // R10: software restart n -> n*8 with gie off
        for (int n = 0; n < 8; n++) begin
            sw_req = 1; sw_num = 3'(n); boundary(); sw_req = 0;
            expect_grant("R10", 6, n * 8);
            chk(gie == 0, "R8", "sw keeps gie", gie, 0);
            tick(); tick();
            chk(req_valid == 1 && req_vector == 16'(n * 8), "R7", "held until ack", req_vector, n * 8);
            do_ack();
            chk(req_valid == 0 && req_vector == 0, "R7", "released by ack", req_vector, 0);
        end

        // R11: enable and mask strobes
        gie_set = 1; mask_wr = 1; mask_in = 3'b000; tick(); gie_set = 0; mask_wr = 0;
        chk(gie == 1 && mask == 0, "R11", "set gie, write mask", {gie, mask}, 4'b1000);
        gie_set = 1; gie_clr = 1; tick(); gie_set = 0; gie_clr = 0;
        chk(gie == 0, "R11", "clear beats set", gie, 0);
        gie_set = 1; tick(); gie_set = 0;

        // R2 R3 R6 R8: level lines and priority
        irq_lvl_hi = 1; irq_lvl_lo = 1; irq_ext = 1;
        gie_set = 1; boundary(); gie_set = 0;
        expect_grant("R2", 3, 'h34);
        chk(gie == 0, "R8", "maskable grant clears gie", gie, 0);
        do_ack();
        boundary();
        expect_none("R6");
        gie_set = 1; mask_wr = 1; mask_in = 3'b010; tick(); gie_set = 0; mask_wr = 0;
        boundary();
        expect_grant("R6", 4, 'h2C);
        do_ack();
        gie_set = 1; mask_wr = 1; mask_in = 3'b011; tick(); gie_set = 0; mask_wr = 0;
        boundary();
        expect_grant("R3", 5, 'h38);
        chk(ext_ack_n == 0, "R9", "ext ack low", ext_ack_n, 0);
        tick();
        chk(ext_ack_n == 1 && req_valid == 1, "R9", "ext ack one cycle", ext_ack_n, 1);
        do_ack();
        irq_lvl_hi = 0; irq_lvl_lo = 0; irq_ext = 0;
        gie_set = 1; mask_wr = 1; mask_in = 3'b000; tick(); gie_set = 0; mask_wr = 0;
        irq_lvl_hi = 1; tick(); irq_lvl_hi = 0; tick();
        boundary();
        expect_none("R6");

        // R5: edge latch
        irq_edge = 1; tick(); irq_edge = 0; tick(); tick();
        boundary();
        expect_grant("R5", 2, 'h3C);
        do_ack();
        gie_set = 1; tick(); gie_set = 0;
        boundary();
        expect_none("R5");
        irq_edge = 1; tick(); irq_edge = 0; edge_clr = 1; tick(); edge_clr = 0;
        boundary();
        expect_none("R5");
        mask_wr = 1; mask_in = 3'b100; tick(); mask_wr = 0;
        irq_edge = 1; tick(); irq_edge = 0;
        boundary();
        expect_none("R6");
        mask_wr = 1; mask_in = 3'b000; tick(); mask_wr = 0;
        boundary();
        expect_grant("R5", 2, 'h3C);
        do_ack();

        // R4: non-maskable line
        chk(gie == 0, "R8", "gie off before nmi", gie, 0);
        irq_nmi = 1; tick();
        boundary();
        expect_grant("R4", 1, 'h24);
        do_ack();
        boundary();
        expect_none("R4");
        irq_nmi = 0; tick(); irq_nmi = 1; tick(); irq_nmi = 0; tick();
        boundary();
        expect_none("R4");

        // R2 R8: nmi above edge and level, nmi keeps gie
        gie_set = 1; tick(); gie_set = 0;
        irq_nmi = 1; irq_edge = 1; irq_lvl_hi = 1; tick(); irq_edge = 0;
        boundary();
        expect_grant("R2", 1, 'h24);
        chk(gie == 1, "R8", "nmi keeps gie", gie, 1);
        do_ack();
        boundary();
        expect_grant("R2", 2, 'h3C);
        do_ack();
        boundary();
        expect_none("R6");
        irq_nmi = 0; irq_lvl_hi = 0;

        // R7: no grant without a boundary
        gie_set = 1; tick(); gie_set = 0;
        irq_ext = 1;
        for (int k = 0; k < 4; k++) begin
            tick();
            expect_none("R7");
        end
        boundary();
        expect_grant("R7", 5, 'h38);
        do_ack();
        irq_ext = 0;
        tick(); tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule